// File: doc/BRIEF.md
# Ordering Table Clear Generator

This block acts as a transfer source that needs no peripheral behind it. From a start address and an entry count, it builds a linked list of empty entries in main memory. The list is chained from high addresses toward low ones. The block issues one word write per cycle on a simple memory write port. Each entry it writes holds the byte address of the entry just below it. The entry at the lowest address holds a fixed end-of-list marker.

A transfer begins with a one-cycle `start` pulse. The block then walks downward in 4-byte steps, whatever direction the surrounding channel uses. All address arithmetic wraps modulo the physical address space. When the memory port drops `mem_ready`, the write strobe stops and all state holds until the port is ready again. After the final write is accepted, `done` pulses for one cycle and the block returns to idle.

The controller has three named states:
- `ST_IDLE` waits for a valid start and moves to `ST_WRITE` on start with a non-zero count.
- `ST_WRITE` issues the entries and moves to `ST_FINISH` when the last entry is accepted.
- `ST_FINISH` raises `done` for one cycle and always returns to `ST_IDLE`.

Top module: `otc_fill_gen`

## Requirements
- R1: After reset, `mem_we`, `busy` and `done` are all low.
- R2: A start with count N (N > 0), taken in `ST_IDLE`, produces exactly N accepted write strobes before `done`.
- R3: The first write goes to the start address with its two low bits cleared. Each later write goes to the previous address minus 4, modulo 2^ADDR_W (24 bits by default).
- R4: Every entry except the last carries, zero-extended to 32 bits, its own write address minus 4 modulo 2^ADDR_W.
- R5: The last entry is written at the aligned start address minus 4·(N−1), modulo 2^ADDR_W. It carries the terminator word 0x00FFFFFF.
- R6: A count of 1 gives a single write: the terminator at the aligned start address.
- R7: While `mem_ready` is low, `mem_we` stays low, and `mem_addr` and `mem_data` hold their values.
- R8: A start pulse is ignored while `busy` is high. A start with a count of 0 is ignored entirely: no write and no `done`.
- R9: The walk wraps through address 0. The entry written at address 0 (when it is not the last) links to 0xFFFFFC.
- R10: `done` is high for exactly one cycle, the cycle after the last write is accepted. `busy` is low on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a fill |
| start_addr | input | ADDR_W | Byte address of the highest (first) entry |
| entry_count | input | CNT_W | Number of entries to write |
| mem_ready | input | 1 | Memory port can accept a write this cycle |
| mem_addr | output | ADDR_W | Byte address of the current write |
| mem_data | output | DATA_W | Word for the current write |
| mem_we | output | 1 | Write strobe; a write is accepted on a clock edge where it is high |
| busy | output | 1 | A fill is in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
Several rules are checked on every cycle:
- the strobe never rises without `mem_ready`;
- address and data hold through a stall;
- each accepted non-final write is followed by a write address 4 lower;
- every write address is word aligned;
- `done` lasts a single cycle and follows a terminator write;
- the entry counter never underflows.

Other behaviour needs the bench's scenarios to show it: the exact write count and the link contents for a given start and count, the wrap through address 0, and that a zero count or a start during a fill changes nothing.

// File: rtl/otc_pkg.sv
package otc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_FINISH = 2'd2
    } otc_state_e;

    localparam int unsigned ENTRY_BYTES = 4;
endpackage

// File: rtl/otc_addr_step.sv
module otc_addr_step #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] link_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(otc_pkg::ENTRY_BYTES);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= {load_addr[ADDR_W-1:2], 2'b00};
        end else if (advance) begin
            addr_q <= addr_q - STEP;
        end
    end

    assign cur_addr  = addr_q;
    assign link_addr = addr_q - STEP;
endmodule

// File: rtl/otc_count.sv
module otc_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_last
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign is_last = (remain_q == CNT_W'(1));

    // R2: a write is never issued once the count is used up
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remain_q != '0));
endmodule

// File: rtl/otc_word_gen.sv
module otc_word_gen #(
    parameter int unsigned     ADDR_W = 24,
    parameter int unsigned     DATA_W = 32,
    parameter logic [DATA_W-1:0] TERM_WORD = DATA_W'(32'h00FF_FFFF)
) (
    input  logic [ADDR_W-1:0] link_addr,
    input  logic              is_last,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] link_word;

    generate
        if (DATA_W > ADDR_W) begin : g_extend
            assign link_word = {{(DATA_W-ADDR_W){1'b0}}, link_addr};
        end else begin : g_trunc
            assign link_word = link_addr[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        word = is_last ? TERM_WORD : link_word;
    end
endmodule

// File: rtl/otc_fill_gen.sv
module otc_fill_gen #(
    parameter int unsigned       ADDR_W = 24,
    parameter int unsigned       DATA_W = 32,
    parameter int unsigned       CNT_W  = 16,
    parameter logic [DATA_W-1:0] TERM_WORD = DATA_W'(32'h00FF_FFFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  entry_count,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_we,
    output logic              busy,
    output logic              done
);
    import otc_pkg::*;

    otc_state_e        state_q, state_d;
    logic              load;
    logic              is_last;
    logic [ADDR_W-1:0] link_addr;

    assign load = (state_q == ST_IDLE) && start && (entry_count != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_WRITE;
            ST_WRITE:  if (mem_ready && is_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_WRITE:  mem_we = mem_ready;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    otc_addr_step #(.ADDR_W(ADDR_W)) addr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (start_addr),
        .advance   (mem_we),
        .cur_addr  (mem_addr),
        .link_addr (link_addr)
    );

    otc_count #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (entry_count),
        .dec      (mem_we),
        .is_last  (is_last)
    );

    otc_word_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TERM_WORD(TERM_WORD)) word_i (
        .link_addr (link_addr),
        .is_last   (is_last),
        .word      (mem_data)
    );

    p_strobe_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_ready);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_data)));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !is_last) |=> (mem_addr == $past(mem_addr) - ADDR_W'(4)));

    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(mem_we) && $past(mem_data) == TERM_WORD));
endmodule

// File: tb/otc_fill_gen_tb.sv
module otc_fill_gen_tb_top;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] entry_count = '0;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_we;
    logic          busy;
    logic          done;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    otc_fill_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .entry_count(entry_count), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_we(mem_we), .busy(busy), .done(done)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int idx);
        logic [AW-1:0] a;
        a = base & ~AW'(3);
        return a - AW'(4 * idx);
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] base, input int idx, input int n);
        if (idx == n - 1) return 32'h00FF_FFFF;
        return {8'h00, exp_addr(base, idx + 1)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One fill; inject_busy_start issues a second start mid-run (R8)
    task automatic run_fill(input logic [AW-1:0] base, input int n, input bit inject_busy_start);
        int writes = 0;
        int iter = 0;
        bit last_seen = 1'b0;
        bit finished = 1'b0;
        @(negedge clk);
        start_addr = base;
        entry_count = CW'(n);
        start = 1'b1;
        while (!finished && iter < n * 12 + 40) begin
            @(negedge clk);
            start = 1'b0;
            if (inject_busy_start && iter == 2) begin
                start = 1'b1;
                start_addr = 24'h55_5550;
                entry_count = 16'd3;
            end
            mem_ready = ($urandom % 4) != 0;
            #1;
            if (done) begin
                check("R2 write count", 64'(writes), 64'(n));
                check("R10 done follows last write", 64'(last_seen), 64'd1);
                finished = 1'b1;
            end else begin
                last_seen = 1'b0;
                if (!mem_ready) begin
                    check("R7 no strobe on stall", 64'(mem_we), 64'd0);
                end
                if (writes < n) begin
                    check("R3 address", 64'(mem_addr), 64'(exp_addr(base, writes)));
                    if (writes == n - 1)
                        check("R5 terminator", 64'(mem_data), 64'(exp_data(base, writes, n)));
                    else
                        check("R4 link word", 64'(mem_data), 64'(exp_data(base, writes, n)));
                end
                if (mem_we) begin
                    writes++;
                    if (writes == n) last_seen = 1'b1;
                end
            end
            iter++;
        end
        if (!finished) check("R2 done reached", 64'd0, 64'd1);
        start = 1'b0;
        @(negedge clk);
        #1;
        check("R10 done one cycle", 64'(done), 64'd0);
        check("R10 busy released", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C1E_A501));
        repeat (3) @(negedge clk);
        #1;
        check("R1 we after reset", 64'(mem_we), 64'd0);
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 done after reset", 64'(done), 64'd0);
        rst_n = 1'b1;

        // R6: single entry
        run_fill(24'h00_1000, 1, 1'b0);
        // R9: wrap through zero (8,4,0,FFFFFC,FFFFF8)
        run_fill(24'h00_0008, 5, 1'b0);
        // R3: unaligned start is aligned
        run_fill(24'h12_3457, 4, 1'b0);
        // top of address space
        run_fill(24'hFF_FFFF, 3, 1'b0);
        // R8: start while busy ignored
        run_fill(24'h20_0400, 10, 1'b1);

        // R8: zero count ignored
        @(negedge clk);
        start_addr = 24'h00_4000;
        entry_count = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            mem_ready = 1'b1;
            #1;
            check("R8 zero count no write", 64'(mem_we), 64'd0);
            check("R8 zero count no done", 64'(done | busy), 64'd0);
            @(negedge clk);
        end

        for (int r = 0; r < 20; r++) begin
            run_fill(AW'($urandom), int'($urandom % 40) + 1, 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule